// File: doc/BRIEF.md
# Operand Address Decoder

This block parses the operand-specifier bytes that come after an instruction opcode in a variable-length encoding. One byte is taken per valid/ready handshake. The first byte names a register field and an operand form. An optional scaled-index byte may follow, and then zero to four displacement bytes. When the last byte has been taken, the block presents the decoded operand for a single cycle, marked by `done`. A register operand is reported by its number. A memory operand is reported as the effective address, computed from the eight general registers supplied on a parallel bus.

The `mode32` input selects the addressing flavour. With it low, the 16-bit register-pair table applies and addresses wrap at 64 KiB. With it high, the 32-bit single-base form applies, and the scaled-index escape is available.

Register numbering throughout is 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI. Register n sits at `regFile[32n+31:32n]`.

Top module: `opnd_addr_decoder`

## Requirements
- R1: While `rst` is high, and in the cycles after it falls, `done` is 0 and `inReady` is 1. A reset in the middle of a parse discards it, so the next byte accepted is treated as a new first byte.
- R2: Bits 5:3 of the first byte appear unchanged on `regOut` while `done` is high.
- R3: When bits 7:6 of the first byte are 11, `done` rises in the cycle after that byte is accepted. `rmIsReg` is 1, `rmReg` equals bits 2:0, and no further bytes are read.
- R4: With `mode32`=0 and a memory form, bits 2:0 of the first byte select the base as follows: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. Each register contributes only its low 16 bits.
- R5: With `mode32`=0, the first byte with bits 7:6=00 and bits 2:0=110 has no base register. Its address is the 16-bit displacement that follows it.
- R6: The displacement length is set by bits 7:6. For 00 there is no displacement. For 01 there is one byte, sign-extended. For 10 there are 2 bytes (`mode32`=0) or 4 bytes (`mode32`=1). Displacement bytes arrive least-significant first.
- R7: With `mode32`=0, the effective address is the sum modulo 2^16, and bits 31:16 of `effAddr` are zero.
- R8: With `mode32`=1 and no scaled-index byte, bits 2:0 name a single base register. Bits 7:6=00 with bits 2:0=101 instead means no base and a 4-byte displacement.
- R9: With `mode32`=1, bits 7:6≠11 and bits 2:0=100, a scaled-index byte follows before any displacement. Its fields are scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The address is base + index×2^scale + displacement. Index 100 contributes no term.
- R10: In the scaled-index byte, base 101 with first-byte bits 7:6=00 means no base register, and a 4-byte displacement follows.
- R11: `done` lasts exactly one cycle, and `inReady` is low only in that cycle. A byte presented then is not taken, and is accepted in the following cycle as a new first byte.
- R12: `byteCount` with `done` equals 1, plus 1 if a scaled-index byte was read, plus the number of displacement bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit |
| inValid | input | 1 | Byte on `inByte` is offered |
| inByte | input | 8 | Operand-specifier byte stream |
| inReady | output | 1 | Block can accept a byte this cycle |
| regFile | input | 256 | Eight 32-bit general registers, register n at bits 32n+31:32n |
| done | output | 1 | One-cycle pulse; decoded operand valid |
| regOut | output | 3 | Register field of the first byte |
| rmIsReg | output | 1 | Second operand is a register |
| rmReg | output | 3 | Register number of the second operand when `rmIsReg` |
| effAddr | output | 32 | Effective address of a memory operand |
| byteCount | output | 3 | Number of bytes consumed |

## Verification
The checker assumes that `mode32` and `regFile` stay steady from the acceptance of a first byte until its `done` pulse. The decode and the address both depend on those inputs at those times. It also tracks the start of each parse from the handshake alone, so it assumes no byte is offered for any purpose other than the operand stream. The bench changes `mode32` only while the block is idle between parses, and it keeps one fixed register set. That set has a nonzero upper half in BX, so the 16-bit truncation is visible.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

  parameter int REG_W    = 32;
  parameter int NUM_REGS = 8;
  parameter int MAX_DISP = 4;
  parameter int NARROW_W = 16;

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int DCNT_W = $clog2(MAX_DISP + 1);
  localparam int BCNT_W = $clog2(MAX_DISP + 3);

  localparam logic [IDX_W-1:0] GPR_BX = 3'd3;
  localparam logic [IDX_W-1:0] GPR_SP = 3'd4;
  localparam logic [IDX_W-1:0] GPR_BP = 3'd5;
  localparam logic [IDX_W-1:0] GPR_SI = 3'd6;
  localparam logic [IDX_W-1:0] GPR_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_FIELD,
    ST_SIB,
    ST_DISP,
    ST_DONE
  } parse_state_e;

  typedef struct packed {
    logic              takeField;
    logic              takeSib;
    logic              takeDisp;
    logic [DCNT_W-1:0] dispIdx;
  } strobe_t;

  // Displacement length from the form bits and the base selector.
  // The base selector is the r/m field, or the scaled-index base field.
  function automatic logic [DCNT_W-1:0] dispBytes(input logic wide,
                                                  input logic [1:0] form,
                                                  input logic [2:0] baseSel);
    logic [DCNT_W-1:0] n;
    case (form)
      2'b01:   n = DCNT_W'(1);
      2'b10:   n = wide ? DCNT_W'(MAX_DISP) : DCNT_W'(2);
      2'b00: begin
        if (wide) n = (baseSel == 3'd5) ? DCNT_W'(MAX_DISP) : '0;
        else      n = (baseSel == 3'd6) ? DCNT_W'(2) : '0;
      end
      default: n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/opnd_addr_ctrl.sv
module opnd_addr_ctrl
  import opnd_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode32,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic [1:0]        formQ,
  output logic              inReady,
  output logic              done,
  output strobe_t           strobe,
  output logic [BCNT_W-1:0] byteCount
);

  parse_state_e      state, stateNext;
  logic [DCNT_W-1:0] dispIdx;
  logic [DCNT_W-1:0] dispLen;
  logic [DCNT_W-1:0] lenNext;
  logic [BCNT_W-1:0] countQ;
  logic              accept;

  assign inReady   = (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign accept    = inValid && inReady;
  assign byteCount = countQ;

  always_comb begin
    strobe           = '0;
    strobe.takeField = accept && (state == ST_FIELD);
    strobe.takeSib   = accept && (state == ST_SIB);
    strobe.takeDisp  = accept && (state == ST_DISP);
    strobe.dispIdx   = dispIdx;
  end

  always_comb begin
    stateNext = state;
    lenNext   = dispLen;
    case (state)
      ST_FIELD: if (accept) begin
        lenNext = dispBytes(mode32, inByte[7:6], inByte[2:0]);
        if (inByte[7:6] == 2'b11) begin
          stateNext = ST_DONE;
        end else if (mode32 && inByte[2:0] == 3'd4) begin
          stateNext = ST_SIB;
        end else begin
          stateNext = (lenNext == '0) ? ST_DONE : ST_DISP;
        end
      end
      ST_SIB: if (accept) begin
        lenNext   = dispBytes(1'b1, formQ, inByte[2:0]);
        stateNext = (lenNext == '0) ? ST_DONE : ST_DISP;
      end
      ST_DISP: if (accept && dispIdx == dispLen - 1'b1) begin
        stateNext = ST_DONE;
      end
      default: stateNext = ST_FIELD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FIELD;
      dispIdx <= '0;
      dispLen <= '0;
      countQ  <= '0;
    end else begin
      state   <= stateNext;
      dispLen <= lenNext;
      if (strobe.takeField) begin
        countQ  <= BCNT_W'(1);
        dispIdx <= '0;
      end else if (strobe.takeSib) begin
        countQ  <= countQ + 1'b1;
      end else if (strobe.takeDisp) begin
        countQ  <= countQ + 1'b1;
        dispIdx <= dispIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/opnd_addr_dpath.sv
module opnd_addr_dpath
  import opnd_addr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode32,
  input  logic [7:0]                inByte,
  input  strobe_t                   strobe,
  input  logic [NUM_REGS*REG_W-1:0] regFile,
  output logic [1:0]                formQ,
  output logic [2:0]                regOut,
  output logic                      rmIsReg,
  output logic [IDX_W-1:0]          rmReg,
  output logic [REG_W-1:0]          effAddr
);

  logic [REG_W-1:0] gpr [NUM_REGS];
  logic             wideQ;
  logic [2:0]       regQ;
  logic [2:0]       rmQ;
  logic [7:0]       sibQ;
  logic             hasSib;
  logic [REG_W-1:0] dispQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign gpr[g] = regFile[g*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wideQ  <= 1'b0;
      formQ  <= 2'b00;
      regQ   <= '0;
      rmQ    <= '0;
      sibQ   <= '0;
      hasSib <= 1'b0;
      dispQ  <= '0;
    end else begin
      if (strobe.takeField) begin
        wideQ  <= mode32;
        formQ  <= inByte[7:6];
        regQ   <= inByte[5:3];
        rmQ    <= inByte[2:0];
        hasSib <= mode32 && (inByte[7:6] != 2'b11) && (inByte[2:0] == 3'd4);
        dispQ  <= '0;
      end
      if (strobe.takeSib) sibQ <= inByte;
      if (strobe.takeDisp) begin
        for (int k = 0; k < MAX_DISP; k++) begin
          if (strobe.dispIdx == DCNT_W'(k)) dispQ[8*k +: 8] <= inByte;
        end
      end
    end
  end

  logic [REG_W-1:0] dispExt;
  logic [REG_W-1:0] termA, termB, wideSum, narrowSum;

  assign dispExt = (formQ == 2'b01) ? {{(REG_W-8){dispQ[7]}}, dispQ[7:0]} : dispQ;

  // 32-bit path: one base plus an optional scaled index.
  always_comb begin
    termA = '0;
    termB = '0;
    if (hasSib) begin
      if (!(formQ == 2'b00 && sibQ[2:0] == 3'd5)) termA = gpr[sibQ[2:0]];
      if (sibQ[5:3] != GPR_SP) termB = gpr[sibQ[5:3]] << sibQ[7:6];
    end else if (!(formQ == 2'b00 && rmQ == 3'd5)) begin
      termA = gpr[rmQ];
    end
    wideSum = termA + termB + dispExt;
  end

  // 16-bit path: register-pair table, low halves only.
  logic [NARROW_W-1:0] pairA, pairB;
  always_comb begin
    pairA = '0;
    pairB = '0;
    case (rmQ)
      3'd0: begin pairA = gpr[GPR_BX][NARROW_W-1:0]; pairB = gpr[GPR_SI][NARROW_W-1:0]; end
      3'd1: begin pairA = gpr[GPR_BX][NARROW_W-1:0]; pairB = gpr[GPR_DI][NARROW_W-1:0]; end
      3'd2: begin pairA = gpr[GPR_BP][NARROW_W-1:0]; pairB = gpr[GPR_SI][NARROW_W-1:0]; end
      3'd3: begin pairA = gpr[GPR_BP][NARROW_W-1:0]; pairB = gpr[GPR_DI][NARROW_W-1:0]; end
      3'd4: pairA = gpr[GPR_SI][NARROW_W-1:0];
      3'd5: pairA = gpr[GPR_DI][NARROW_W-1:0];
      3'd6: if (formQ != 2'b00) pairA = gpr[GPR_BP][NARROW_W-1:0];
      default: pairA = gpr[GPR_BX][NARROW_W-1:0];
    endcase
    narrowSum = {{(REG_W-NARROW_W){1'b0}}, pairA} + {{(REG_W-NARROW_W){1'b0}}, pairB} + dispExt;
  end

  assign effAddr = wideQ ? wideSum : {{(REG_W-NARROW_W){1'b0}}, narrowSum[NARROW_W-1:0]};
  assign regOut  = regQ;
  assign rmIsReg = (formQ == 2'b11);
  assign rmReg   = rmQ;

endmodule

// File: rtl/opnd_addr_decoder.sv
module opnd_addr_decoder
  import opnd_addr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode32,
  input  logic                      inValid,
  input  logic [7:0]                inByte,
  output logic                      inReady,
  input  logic [NUM_REGS*REG_W-1:0] regFile,
  output logic                      done,
  output logic [2:0]                regOut,
  output logic                      rmIsReg,
  output logic [IDX_W-1:0]          rmReg,
  output logic [REG_W-1:0]          effAddr,
  output logic [BCNT_W-1:0]         byteCount
);

  strobe_t    strobe;
  logic [1:0] formQ;

  opnd_addr_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode32    (mode32),
    .inValid   (inValid),
    .inByte    (inByte),
    .formQ     (formQ),
    .inReady   (inReady),
    .done      (done),
    .strobe    (strobe),
    .byteCount (byteCount)
  );

  opnd_addr_dpath i_dpath (
    .clk     (clk),
    .rst     (rst),
    .mode32  (mode32),
    .inByte  (inByte),
    .strobe  (strobe),
    .regFile (regFile),
    .formQ   (formQ),
    .regOut  (regOut),
    .rmIsReg (rmIsReg),
    .rmReg   (rmReg),
    .effAddr (effAddr)
  );

endmodule

// File: rtl/opnd_addr_checker.sv
module opnd_addr_checker
  import opnd_addr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mode32,
  input logic              inValid,
  input logic [7:0]        inByte,
  input logic              inReady,
  input logic              done,
  input logic [2:0]        regOut,
  input logic              rmIsReg,
  input logic [REG_W-1:0]  effAddr,
  input logic [BCNT_W-1:0] byteCount
);

  logic       firstPhase;
  logic [2:0] seenReg;
  logic       take;

  assign take = inValid && inReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      firstPhase <= 1'b1;
      seenReg    <= '0;
    end else begin
      if (done) firstPhase <= 1'b1;
      else if (take) firstPhase <= 1'b0;
      if (take && firstPhase) seenReg <= inByte[5:3];
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R11
  AST_STALL_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !inReady);  // R11
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> inReady);  // R11
  AST_REG_FORM_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (take && firstPhase && inByte[7:6] == 2'b11) |=> (done && rmIsReg && byteCount == 1));  // R3
  AST_REG_FIELD_KEPT: assert property (@(posedge clk) disable iff (rst)
    done |-> regOut == seenReg);  // R2
  AST_COUNT_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    done |-> (byteCount >= 1 && byteCount <= 6));  // R12
  AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (done && !rmIsReg && !mode32) |-> effAddr[REG_W-1:NARROW_W] == '0);  // R7
  AST_NARROW_NO_DISP: assert property (@(posedge clk) disable iff (rst)
    (take && firstPhase && !mode32 && inByte[7:6] == 2'b00 && inByte[2:0] != 3'd6)
      |=> (done && byteCount == 1));  // R4

endmodule

bind opnd_addr_decoder opnd_addr_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .mode32    (mode32),
  .inValid   (inValid),
  .inByte    (inByte),
  .inReady   (inReady),
  .done      (done),
  .regOut    (regOut),
  .rmIsReg   (rmIsReg),
  .effAddr   (effAddr),
  .byteCount (byteCount)
);

// File: tb/test_opnd_addr_decoder.sv
module test_opnd_addr_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        m32;
    logic [47:0] bytes;   // byte k at bits 8k+7:8k, sent from k=0
    logic [2:0]  expReg;
    logic        expIsReg;
    logic [2:0]  expRm;
    logic [31:0] expEa;
    logic [2:0]  expCnt;
  } vec_t;

  // Registers: AX=10 CX=20 DX=30 BX=55551000 SP=40 BP=2000 SI=100 DI=200
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 48'h0000000000C3, 3'd0, 1'b1, 3'd3, 32'h0,        3'd1},
    '{1'b0, 48'h000000000000, 3'd0, 1'b0, 3'd0, 32'h00001100, 3'd1},
    '{1'b0, 48'h00000000003B, 3'd7, 1'b0, 3'd0, 32'h00002200, 3'd1},
    '{1'b0, 48'h000000123416, 3'd2, 1'b0, 3'd0, 32'h00001234, 3'd3},
    '{1'b0, 48'h00000000F046, 3'd0, 1'b0, 3'd0, 32'h00001FF0, 3'd2},
    '{1'b0, 48'h00000000108C, 3'd1, 1'b0, 3'd0, 32'h00000110, 3'd3},
    '{1'b0, 48'h000000F00087, 3'd0, 1'b0, 3'd0, 32'h00000000, 3'd3},
    '{1'b0, 48'h000000007F45, 3'd0, 1'b0, 3'd0, 32'h0000027F, 3'd2},
    '{1'b1, 48'h000000000003, 3'd0, 1'b0, 3'd0, 32'h55551000, 3'd1},
    '{1'b1, 48'h00123456780D, 3'd1, 1'b0, 3'd0, 32'h12345678, 3'd5},
    '{1'b1, 48'h000000000045, 3'd0, 1'b0, 3'd0, 32'h00002000, 3'd2},
    '{1'b1, 48'h000001000086, 3'd0, 1'b0, 3'd0, 32'h00010100, 3'd5},
    '{1'b1, 48'h000000FC8B44, 3'd0, 1'b0, 3'd0, 32'h5555107C, 3'd3},
    '{1'b1, 48'hDEADBEEF2504, 3'd0, 1'b0, 3'd0, 32'hDEADBEEF, 3'd6},
    '{1'b1, 48'h00000000F014, 3'd2, 1'b0, 3'd0, 32'h00000810, 3'd2},
    '{1'b1, 48'h000000806554, 3'd2, 1'b0, 3'd0, 32'h00001F80, 3'd3},
    '{1'b1, 48'h800000014EA4, 3'd4, 1'b0, 3'd0, 32'h80000141, 3'd6},
    '{1'b1, 48'h0000000000DF, 3'd3, 1'b1, 3'd7, 32'h0,        3'd1}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         mode32;
  logic         inValid;
  logic [7:0]   inByte;
  logic         inReady;
  logic [255:0] regFile;
  logic         done;
  logic [2:0]   regOut;
  logic         rmIsReg;
  logic [2:0]   rmReg;
  logic [31:0]  effAddr;
  logic [2:0]   byteCount;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_decoder i_opnd_addr_decoder (
    .clk(clk), .rst(rst), .mode32(mode32), .inValid(inValid), .inByte(inByte),
    .inReady(inReady), .regFile(regFile), .done(done), .regOut(regOut),
    .rmIsReg(rmIsReg), .rmReg(rmReg), .effAddr(effAddr), .byteCount(byteCount)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic string eaTag(input int i);
    case (i)
      1, 2:            return "R4 address";
      3:               return "R5 address";
      4, 5, 7, 10, 11: return "R6 address";
      6:               return "R7 address";
      8, 9:            return "R8 address";
      13, 15:          return "R10 address";
      default:         return "R9 address";
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R11 watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst     = 1'b1;
    mode32  = 1'b0;
    inValid = 1'b0;
    inByte  = 8'h00;
    regFile = {32'h00000200, 32'h00000100, 32'h00002000, 32'h00000040,
               32'h55551000, 32'h00000030, 32'h00000020, 32'h00000010};
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    check(inReady == 1'b1, "R1 ready in reset", 32'(inReady), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      mode32 = VECS[i].m32;
      for (int k = 0; k < int'(VECS[i].expCnt); k++) begin
        sendByte(VECS[i].bytes[8*k +: 8]);
      end
      check(done == 1'b1, "R11 done after last byte", 32'(done), 32'd1);
      check(regOut == VECS[i].expReg, "R2 reg field", 32'(regOut), 32'(VECS[i].expReg));
      check(rmIsReg == VECS[i].expIsReg, "R3 register flag", 32'(rmIsReg), 32'(VECS[i].expIsReg));
      if (VECS[i].expIsReg)
        check(rmReg == VECS[i].expRm, "R3 register number", 32'(rmReg), 32'(VECS[i].expRm));
      else
        check(effAddr == VECS[i].expEa, eaTag(i), effAddr, VECS[i].expEa);
      check(byteCount == VECS[i].expCnt, "R12 byte count", 32'(byteCount), 32'(VECS[i].expCnt));
      @(negedge clk);
      check(done == 1'b0, "R11 done pulse ends", 32'(done), 32'd0);
    end

    // R11: byte offered in the done cycle is not taken, then taken next
    mode32  = 1'b0;
    inValid = 1'b1;
    inByte  = 8'hC0;
    @(negedge clk);
    check(done == 1'b1 && rmReg == 3'd0, "R11 first back-to-back", 32'(rmReg), 32'd0);
    check(inReady == 1'b0, "R11 stall in done cycle", 32'(inReady), 32'd0);
    inByte = 8'hC1;
    @(negedge clk);
    check(done == 1'b0 && inReady == 1'b1, "R11 idle after done", 32'({done, inReady}), 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    check(done == 1'b1 && rmReg == 3'd1, "R11 held byte accepted", 32'(rmReg), 32'd1);
    check(byteCount == 3'd1, "R11 held byte count", 32'(byteCount), 32'd1);
    @(negedge clk);

    // R1: reset mid-parse discards the partial operand
    mode32 = 1'b1;
    sendByte(8'h86);
    sendByte(8'h11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(done == 1'b0 && inReady == 1'b1, "R1 mid-parse reset", 32'({done, inReady}), 32'd1);
    sendByte(8'hC2);
    check(done == 1'b1, "R1 new parse after reset", 32'(done), 32'd1);
    check(byteCount == 3'd1 && rmReg == 3'd2, "R1 fresh first byte", 32'({byteCount, rmReg}), 32'h0A);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule